// File: doc/BRIEF.md
# Block-Write Output-Enable Configuration Slave

This block is a two-wire serial slave that holds a small bank of 8-bit output-enable registers for a clock buffer. A bus master selects it with a 7-bit address. In a write transfer the master then sends two bytes that the slave must acknowledge but never uses: a command byte and a byte-count byte. Every byte after those two is a data byte. Data bytes fill register 0, then register 1, and so on, until the master ends the transfer. There is no way to address one register on its own. The write pointer always starts from register 0.

In a read transfer the slave returns the registers from register 0 upward, with no byte count in front, so the master can check what it wrote. Each register bit is brought out on `cfg_en` and controls the enable of one buffered clock. An active-low power-down input makes the slave let go of the data line and ignore the bus. The registers keep their contents through power-down.

Both bus lines are sampled by the system clock through synchronizer chains. A START is an SDA fall while SCL is high. A STOP is an SDA rise while SCL is high. The slave never drives SCL. It pulls SDA low through `sda_oe` only to acknowledge a byte or to send a zero data bit.

Top module: `clkbuf_cfg_i2c`

## Requirements
- R1: After reset every register holds 0xFF, so `cfg_en` is all ones, and `sda_oe` is low.
- R2: The address byte is the 7-bit `SLAVE_ADDR` (default 0x69) followed by a read/write bit, sent MSB first. A matching address is acknowledged by holding SDA low during the ninth clock. A mismatch gets no acknowledge, and every byte up to the next START is neither acknowledged nor stored.
- R3: In a write transfer the first two bytes after the address are acknowledged and discarded.
- R4: Data bytes are stored in order into register 0, 1, 2. Register k appears on `cfg_en[8k+7:8k]`.
- R5: A STOP after any complete byte ends the transfer. Registers written in that transfer keep their new values, and all other registers keep their old ones.
- R6: Every byte of a selected write is acknowledged, including data bytes beyond the last register. Those extra bytes change no register.
- R7: With read/write bit 1, the slave sends register 0, 1, 2 in order, MSB first, with no leading count byte. Reads past the last register return 0xFF. A master NACK ends the slave's sending.
- R8: While `pwr_dn_n` is low, `sda_oe` stays low, no byte is acknowledged and no register changes. The stored values remain after `pwr_dn_n` returns high.
- R9: A repeated START begins a new transfer. The slave expects an address byte again, and both the write pointer and the read pointer return to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_dn_n | input | 1 | Active-low power-down; releases the bus and freezes the registers |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | When high, the pad pulls SDA low |
| cfg_en | output | NUM_REGS*8 | Register contents; one enable bit per clock output |

## Verification
The bench builds the block with the default address 0x69, three registers, two skipped bytes and a three-stage synchronizer. The extra synchronizer stage adds latency between an SCL edge and the slave's SDA response, and the bench's bus timing must still work with that. With only three registers, a five-byte data burst already runs past the end of the bank, and a four-byte read reaches the 0xFF fill value. A repeated START placed after one data byte leaves the write pointer at register 1. That position shows whether the pointer is reset, because the next address byte would otherwise be stored in register 1.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;
   localparam int unsigned BYTE_W = 8;

   typedef enum logic [2:0] {
      LS_IDLE,
      LS_ADDR,
      LS_ADDR_ACK,
      LS_WR_BYTE,
      LS_WR_ACK,
      LS_RD_BYTE,
      LS_RD_ACK,
      LS_IGNORE
   } link_state_e;
endpackage

// File: rtl/cfgi2c_sync.sv
module cfgi2c_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_LVL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_i,
   output logic level_o,
   output logic rise_o,
   output logic fall_o
);
   logic [STAGES-1:0] chain;
   logic              prev;

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfgi2c_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_LVL}};
         prev  <= RST_LVL;
      end else begin
         chain <= {chain[STAGES-2:0], async_i};
         prev  <= chain[STAGES-1];
      end
   end

   assign level_o = chain[STAGES-1];
   assign rise_o  = chain[STAGES-1] & ~prev;
   assign fall_o  = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/cfgi2c_cond.sv
module cfgi2c_cond (
   input  logic scl_lvl,
   input  logic sda_rise,
   input  logic sda_fall,
   output logic start_o,
   output logic stop_o
);
   assign start_o = sda_fall & scl_lvl;
   assign stop_o  = sda_rise & scl_lvl;
endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank #(
   parameter int unsigned NUM_REGS = 3,
   parameter logic [7:0]  REG_RST  = 8'hFF,
   parameter int unsigned IDXW     = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [IDXW-1:0]       wr_idx,
   input  logic [7:0]            wr_data,
   input  logic [IDXW-1:0]       rd_idx,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] regs_flat
);
   genvar g;
   generate
      for (g = 0; g < NUM_REGS; g++) begin : g_reg
         logic [7:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= REG_RST;
            else if (wr_en && (wr_idx == IDXW'(g)))
               q <= wr_data;
         end
         assign regs_flat[g*8 +: 8] = q;
      end
   endgenerate

   always_comb begin
      rd_data = 8'hFF;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_idx == IDXW'(i))
            rd_data = regs_flat[i*8 +: 8];
      end
   end

   // R7: reads beyond the bank return the fill value
   p_rd_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_idx >= IDXW'(NUM_REGS)) |-> (rd_data == 8'hFF));
endmodule

// File: rtl/cfgi2c_link.sv
module cfgi2c_link
   import cfgi2c_pkg::*;
#(
   parameter logic [6:0]  SLAVE_ADDR = 7'h69,
   parameter int unsigned SKIP_BYTES = 2,
   parameter int unsigned NUM_REGS   = 3,
   parameter int unsigned IDXW       = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            enable,
   input  logic            sda_lvl,
   input  logic            scl_rise,
   input  logic            scl_fall,
   input  logic            start,
   input  logic            stop,
   input  logic [7:0]      rd_data,
   output logic            sda_drv,
   output logic            wr_en,
   output logic [IDXW-1:0] wr_idx,
   output logic [7:0]      wr_data,
   output logic [IDXW-1:0] rd_idx
);
   localparam int unsigned SKW = (SKIP_BYTES < 1) ? 1 : $clog2(SKIP_BYTES + 1);
   localparam logic [SKW-1:0]  SKIP_DONE = SKW'(SKIP_BYTES);
   localparam logic [IDXW-1:0] PTR_END   = IDXW'(NUM_REGS);
   localparam logic [3:0]      BITS_FULL = 4'(BYTE_W);

   link_state_e       state;
   logic [3:0]        bit_cnt;
   logic [7:0]        shreg;
   logic [SKW-1:0]    skip_cnt;
   logic [IDXW-1:0]   ptr;
   logic              rw;
   logic              ack_n;
   logic              byte_in_done;
   logic              ptr_room;

   assign byte_in_done = scl_fall && (bit_cnt == BITS_FULL);
   assign ptr_room     = (ptr < PTR_END);

   assign wr_en   = enable && !start && !stop && (state == LS_WR_BYTE) &&
                    byte_in_done && (skip_cnt == SKIP_DONE) && ptr_room;
   assign wr_idx  = ptr;
   assign wr_data = shreg;
   assign rd_idx  = ptr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= LS_IDLE;
         bit_cnt  <= '0;
         shreg    <= '0;
         skip_cnt <= '0;
         ptr      <= '0;
         rw       <= 1'b0;
         ack_n    <= 1'b1;
         sda_drv  <= 1'b0;
      end else if (!enable) begin
         state   <= LS_IDLE;
         bit_cnt <= '0;
         sda_drv <= 1'b0;
      end else if (start) begin
         state    <= LS_ADDR;
         bit_cnt  <= '0;
         skip_cnt <= '0;
         ptr      <= '0;
         sda_drv  <= 1'b0;
      end else if (stop) begin
         state   <= LS_IDLE;
         sda_drv <= 1'b0;
      end else begin
         unique case (state)
            LS_ADDR, LS_WR_BYTE: begin
               if (scl_rise && (bit_cnt < BITS_FULL)) begin
                  shreg   <= {shreg[6:0], sda_lvl};
                  bit_cnt <= bit_cnt + 4'd1;
               end else if (byte_in_done) begin
                  bit_cnt <= '0;
                  if (state == LS_ADDR) begin
                     if (shreg[7:1] == SLAVE_ADDR) begin
                        rw      <= shreg[0];
                        sda_drv <= 1'b1;
                        state   <= LS_ADDR_ACK;
                     end else begin
                        state <= LS_IGNORE;
                     end
                  end else begin
                     sda_drv <= 1'b1;
                     state   <= LS_WR_ACK;
                     if (skip_cnt != SKIP_DONE)
                        skip_cnt <= skip_cnt + 1'b1;
                     else if (ptr_room)
                        ptr <= ptr + 1'b1;
                  end
               end
            end
            LS_ADDR_ACK: begin
               if (scl_fall) begin
                  if (rw) begin
                     shreg   <= rd_data;
                     sda_drv <= ~rd_data[7];
                     bit_cnt <= '0;
                     state   <= LS_RD_BYTE;
                     if (ptr_room) ptr <= ptr + 1'b1;
                  end else begin
                     sda_drv <= 1'b0;
                     state   <= LS_WR_BYTE;
                  end
               end
            end
            LS_WR_ACK: begin
               if (scl_fall) begin
                  sda_drv <= 1'b0;
                  state   <= LS_WR_BYTE;
               end
            end
            LS_RD_BYTE: begin
               if (scl_fall) begin
                  if (bit_cnt == 4'd7) begin
                     sda_drv <= 1'b0;
                     state   <= LS_RD_ACK;
                  end else begin
                     bit_cnt <= bit_cnt + 4'd1;
                     shreg   <= {shreg[6:0], 1'b0};
                     sda_drv <= ~shreg[6];
                  end
               end
            end
            LS_RD_ACK: begin
               if (scl_rise) begin
                  ack_n <= sda_lvl;
               end else if (scl_fall) begin
                  if (!ack_n) begin
                     shreg   <= rd_data;
                     sda_drv <= ~rd_data[7];
                     bit_cnt <= '0;
                     state   <= LS_RD_BYTE;
                     if (ptr_room) ptr <= ptr + 1'b1;
                  end else begin
                     state <= LS_IGNORE;
                  end
               end
            end
            default: begin
            end
         endcase
      end
   end

   // R2 R6: the slave never pulls SDA while it is receiving or idle
   p_rx_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ((state == LS_ADDR) || (state == LS_WR_BYTE) ||
       (state == LS_IGNORE) || (state == LS_IDLE)) |-> !sda_drv);

   // R6: a complete write byte is always followed by an acknowledge
   p_ack_after_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !start && !stop && (state == LS_WR_BYTE) && byte_in_done)
      |=> (sda_drv && (state == LS_WR_ACK)));

   // R9: START always restarts at the address phase
   p_start_restarts_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && start) |=> ((state == LS_ADDR) && (bit_cnt == 4'd0) && (ptr == '0)));

   // R5: STOP returns the link to idle
   p_stop_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && stop && !start) |=> (state == LS_IDLE));
endmodule

// File: rtl/clkbuf_cfg_i2c.sv
module clkbuf_cfg_i2c #(
   parameter logic [6:0]  SLAVE_ADDR  = 7'h69,
   parameter int unsigned NUM_REGS    = 3,
   parameter int unsigned SKIP_BYTES  = 2,
   parameter int unsigned SYNC_STAGES = 2,
   parameter logic [7:0]  REG_RST     = 8'hFF
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  pwr_dn_n,
   input  logic                  scl_i,
   input  logic                  sda_i,
   output logic                  sda_oe,
   output logic [NUM_REGS*8-1:0] cfg_en
);
   localparam int unsigned IDXW = $clog2(NUM_REGS + 1);

   generate
      if ((NUM_REGS < 1) || (NUM_REGS > 64)) begin : g_bad_regs
         $error("clkbuf_cfg_i2c: NUM_REGS out of range 1..64");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("clkbuf_cfg_i2c: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic scl_lvl, scl_rise, scl_fall;
   logic sda_lvl, sda_rise, sda_fall;
   logic start_w, stop_w;
   logic sda_drv_w, wr_en_w;
   logic [IDXW-1:0] wr_idx_w, rd_idx_w;
   logic [7:0] wr_data_w, rd_data_w;

   cfgi2c_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .async_i(scl_i),
      .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall));

   cfgi2c_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .async_i(sda_i),
      .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall));

   cfgi2c_cond u_cond (
      .scl_lvl(scl_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
      .start_o(start_w), .stop_o(stop_w));

   cfgi2c_link #(
      .SLAVE_ADDR(SLAVE_ADDR), .SKIP_BYTES(SKIP_BYTES),
      .NUM_REGS(NUM_REGS), .IDXW(IDXW)
   ) u_link (
      .clk(clk), .rst_n(rst_n), .enable(pwr_dn_n),
      .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .start(start_w), .stop(stop_w), .rd_data(rd_data_w),
      .sda_drv(sda_drv_w), .wr_en(wr_en_w), .wr_idx(wr_idx_w),
      .wr_data(wr_data_w), .rd_idx(rd_idx_w));

   cfgi2c_regbank #(.NUM_REGS(NUM_REGS), .REG_RST(REG_RST), .IDXW(IDXW)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en_w), .wr_idx(wr_idx_w),
      .wr_data(wr_data_w), .rd_idx(rd_idx_w), .rd_data(rd_data_w),
      .regs_flat(cfg_en));

   assign sda_oe = sda_drv_w & pwr_dn_n;

   // R8: power-down clears the internal drive request on the next edge
   p_pd_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_dn_n |=> !sda_drv_w);

   // R8: register contents are frozen while powered down
   p_pd_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_dn_n |=> $stable(cfg_en));
endmodule

// File: tb/sim_clkbuf_cfg_i2c.sv
module sim_clkbuf_cfg_i2c;
   localparam int Q = 10;
   localparam logic [7:0] AW = 8'hD2;   // 0x69 << 1, write
   localparam logic [7:0] AR = 8'hD3;   // 0x69 << 1, read

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic rst_n, pwr_dn_n, m_sda_low, m_scl_low;
   logic sda_oe;
   logic [23:0] cfg_en;
   logic sda_line, scl_line;
   assign sda_line = ~(m_sda_low | sda_oe);
   assign scl_line = ~m_scl_low;

   int checks = 0;
   int errors = 0;

   clkbuf_cfg_i2c #(.SYNC_STAGES(3)) u0 (
      .clk(clk), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n),
      .scl_i(scl_line), .sda_i(sda_line), .sda_oe(sda_oe), .cfg_en(cfg_en));

   task automatic waitq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic bus_start();
      m_sda_low = 1'b0; waitq();
      m_scl_low = 1'b0; waitq();
      m_sda_low = 1'b1; waitq();
      m_scl_low = 1'b1; waitq();
   endtask

   task automatic bus_stop();
      m_sda_low = 1'b1; waitq();
      m_scl_low = 1'b0; waitq();
      m_sda_low = 1'b0; waitq();
   endtask

   task automatic put_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) begin
         m_sda_low = ~b[i]; waitq();
         m_scl_low = 1'b0; waitq(); waitq();
         m_scl_low = 1'b1; waitq();
      end
      m_sda_low = 1'b0; waitq();
      m_scl_low = 1'b0; waitq();
      ack = sda_line; waitq();
      m_scl_low = 1'b1; waitq();
   endtask

   task automatic get_byte(input logic give_ack, output logic [7:0] b);
      m_sda_low = 1'b0;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         waitq();
         m_scl_low = 1'b0; waitq();
         b = {b[6:0], sda_line}; waitq();
         m_scl_low = 1'b1;
      end
      waitq();
      m_sda_low = give_ack; waitq();
      m_scl_low = 1'b0; waitq(); waitq();
      m_scl_low = 1'b1; waitq();
      m_sda_low = 1'b0;
   endtask

   task automatic t_reset_r1();
      chk("R1 cfg_en", cfg_en, 32'hFFFFFF);
      chk("R1 sda_oe", sda_oe, 0);
   endtask

   task automatic t_skip_early_stop();
      logic a;
      bus_start();
      put_byte(AW, a);   chk("R2 address ack", a, 0);
      put_byte(8'h12, a); chk("R3 command ack", a, 0);
      put_byte(8'h34, a); chk("R3 count ack", a, 0);
      put_byte(8'hA5, a); chk("R6 data ack", a, 0);
      bus_stop();
      chk("R3 reg0 after skipped bytes", cfg_en[7:0], 8'hA5);
      chk("R5 reg1 untouched", cfg_en[15:8], 8'hFF);
      chk("R5 reg2 untouched", cfg_en[23:16], 8'hFF);
   endtask

   task automatic t_sequential_overrun();
      logic a;
      logic [7:0] d [5] = '{8'h11, 8'h22, 8'h33, 8'h44, 8'h55};
      bus_start();
      put_byte(AW, a); put_byte(8'h00, a); put_byte(8'h00, a);
      for (int i = 0; i < 5; i++) begin
         put_byte(d[i], a);
         chk("R6 ack every data byte", a, 0);
      end
      bus_stop();
      chk("R4 order", cfg_en, 32'h332211);
   endtask

   task automatic t_bad_address_r2();
      logic a;
      bus_start();
      put_byte(8'hA0, a); chk("R2 no ack on mismatch", a, 1);
      put_byte(8'h00, a); put_byte(8'h00, a);
      put_byte(8'h77, a); chk("R2 ignored data not acked", a, 1);
      bus_stop();
      chk("R2 regs unchanged", cfg_en, 32'h332211);
   endtask

   task automatic t_read_r7();
      logic a;
      logic [7:0] b;
      bus_start();
      put_byte(AR, a); chk("R7 read address ack", a, 0);
      get_byte(1'b1, b); chk("R7 byte0", b, 8'h11);
      get_byte(1'b1, b); chk("R7 byte1", b, 8'h22);
      get_byte(1'b1, b); chk("R7 byte2", b, 8'h33);
      get_byte(1'b0, b); chk("R7 past end", b, 8'hFF);
      chk("R7 released after nack", sda_oe, 0);
      bus_stop();
   endtask

   task automatic t_repeated_start_r9();
      logic a;
      logic [7:0] b;
      bus_start();
      put_byte(AW, a); put_byte(8'h00, a); put_byte(8'h00, a);
      put_byte(8'h66, a);
      bus_start();
      put_byte(AW, a); chk("R9 address after rstart", a, 0);
      put_byte(8'h00, a); put_byte(8'h00, a);
      put_byte(8'h99, a);
      bus_start();
      put_byte(AR, a);
      get_byte(1'b0, b); chk("R9 read restarts at reg0", b, 8'h99);
      bus_stop();
      chk("R9 reg0", cfg_en[7:0], 8'h99);
      chk("R9 reg1 kept", cfg_en[15:8], 8'h22);
   endtask

   task automatic t_power_down_r8();
      logic a;
      logic [7:0] b;
      pwr_dn_n = 1'b0; waitq();
      chk("R8 sda released", sda_oe, 0);
      bus_start();
      put_byte(AW, a); chk("R8 no ack in power-down", a, 1);
      put_byte(8'h00, a); put_byte(8'h00, a); put_byte(8'h5A, a);
      bus_stop();
      chk("R8 regs frozen", cfg_en, 32'h332299);
      pwr_dn_n = 1'b1; waitq();
      bus_start();
      put_byte(AR, a); chk("R8 ack after wake", a, 0);
      get_byte(1'b0, b); chk("R8 reg0 retained", b, 8'h99);
      bus_stop();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      rst_n = 1'b0; pwr_dn_n = 1'b1; m_sda_low = 1'b0; m_scl_low = 1'b0;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      waitq();
      t_reset_r1();
      t_skip_early_stop();
      t_sequential_overrun();
      t_bad_address_r2();
      t_read_r7();
      t_repeated_start_r9();
      t_power_down_r8();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule